// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block is the central scheduler of a small processor whose function units are not pipelined. One decoded instruction is presented at a time, naming the unit it needs, a destination register and two source registers. The block accepts it only in program order, then lets each unit read its operands, execute and write back out of order. It keeps the whole hazard picture in one place: a busy phase for every unit, a pending-producer tag for every register, and for every occupied unit its registers plus one ready flag per source.

Each hazard class is settled at a different step. Unit conflicts and write-after-write are stalled at issue. Read-after-write is held at the operand read. Write-after-read is held at write-back. There is no forwarding: a consumer may read only once its producer has been granted the register write port, and that single port goes to the lowest-numbered eligible unit. An executing unit raises its done request and holds it until it sees its write grant. The grant outputs are combinational from the tracking state and the current inputs.

Top module: `sb_issue_scoreboard`

## Requirements
- R1: After reset every unit is idle and no register has a pending producer, so a valid instruction issues at once and no read or write grant is given, even when every done request is high.
- R2: `issue_ok` stays low while the unit selected by `in_unit` holds an instruction in any phase.
- R3: `issue_ok` stays low while another in-flight instruction has the same destination register.
- R4: `issue_ok` is low whenever `in_valid` is low.
- R5: A unit whose sources had no pending producer at issue gets its `rd_grant` bit in the cycle after issue. A unit gets `rd_grant` only when both sources are ready, and it then leaves the waiting phase.
- R6: A source that had a pending producer becomes ready at the producer's write grant, so the consumer's `rd_grant` comes in the cycle after that `wr_grant`.
- R7: An instruction issued in the same cycle as the write grant of its source's producer counts that source as ready.
- R8: `wr_grant` goes only to a unit that has read its operands and raises `done_req`. A done request from an idle or still-waiting unit is ignored.
- R9: A unit may not be granted the write while another waiting unit, with the matching source flag ready but not yet read, names the same register as a source. The grant can come in the cycle after that reader's `rd_grant`.
- R10: At most one `wr_grant` bit is set per cycle, and it goes to the lowest-numbered eligible unit. A unit that loses keeps its request and wins in a later cycle.
- R11: With a write grant, `wr_reg` gives the granted unit's destination. The grant frees the unit and clears the register's pending tag, so a later instruction may use either from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_unit | input | $clog2(NUM_FU) | Function unit the instruction needs |
| in_dst | input | $clog2(NUM_REGS) | Destination register |
| in_src1 | input | $clog2(NUM_REGS) | First source register |
| in_src2 | input | $clog2(NUM_REGS) | Second source register |
| done_req | input | NUM_FU | Per-unit request to write the finished result |
| issue_ok | output | 1 | The presented instruction is accepted this cycle |
| rd_grant | output | NUM_FU | Per-unit permission to read operands this cycle |
| wr_grant | output | NUM_FU | Per-unit permission to write its result this cycle |
| wr_reg | output | $clog2(NUM_REGS) | Destination register of the granted write |

## Verification
The bench goes after the cycles in which two hazard rules meet. A writer that finishes while an earlier reader still holds a ready copy of the old value must wait until that reader's read grant has passed. A design that compared tags instead of register numbers would let it through and corrupt the reader. An instruction issued in the very cycle its producer writes must not wait for a tag that is already gone. A design without that bypass would deadlock the consumer. Simultaneous done requests must give the lowest unit the port and keep the other request pending. Done requests from units that have not read are checked for being ignored, since granting them would retire an instruction that never executed.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // life cycle of one function-unit slot
  typedef enum logic [1:0] {
    UNIT_IDLE = 2'd0,
    UNIT_WAIT = 2'd1,
    UNIT_EXEC = 2'd2
  } unit_phase_e;
endpackage

// File: rtl/sb_reg_tags.sv
module sb_reg_tags #(
  parameter int NUM_REGS = 8,
  parameter int TW       = 3,
  parameter logic [TW-1:0] NONE = '1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        set_en,
  input  logic [$clog2(NUM_REGS)-1:0] set_reg,
  input  logic [TW-1:0]               set_tag,
  input  logic                        clr_en,
  input  logic [$clog2(NUM_REGS)-1:0] clr_reg,
  input  logic [$clog2(NUM_REGS)-1:0] look_dst,
  input  logic [$clog2(NUM_REGS)-1:0] look_s1,
  input  logic [$clog2(NUM_REGS)-1:0] look_s2,
  output logic [TW-1:0]               tag_dst,
  output logic [TW-1:0]               tag_s1,
  output logic [TW-1:0]               tag_s2
);
  logic [TW-1:0] tags [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) tags[i] <= NONE;
    end else begin
      if (clr_en) tags[clr_reg] <= NONE;
      if (set_en) tags[set_reg] <= set_tag;
    end
  end

  assign tag_dst = tags[look_dst];
  assign tag_s1  = tags[look_s1];
  assign tag_s2  = tags[look_s2];

  // R3
  waw_free_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |-> tags[set_reg] == NONE);

  // R11
  tag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && set_reg == clr_reg)) |=> tags[$past(clr_reg)] == NONE);
endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot #(
  parameter int RW = 3,
  parameter int TW = 3,
  parameter logic [TW-1:0] NONE = '1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issue_en,
  input  logic [RW-1:0]           iss_dst,
  input  logic [RW-1:0]           iss_src1,
  input  logic [RW-1:0]           iss_src2,
  input  logic [TW-1:0]           iss_q1,
  input  logic [TW-1:0]           iss_q2,
  input  logic                    rd_go,
  input  logic                    wr_go,
  input  logic                    wb_valid,
  input  logic [TW-1:0]           wb_tag,
  output sb_pkg::unit_phase_e     phase,
  output logic [RW-1:0]           dst_o,
  output logic [RW-1:0]           src1_o,
  output logic [RW-1:0]           src2_o,
  output logic                    rdy1_o,
  output logic                    rdy2_o
);
  import sb_pkg::*;

  logic [TW-1:0] q1, q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= UNIT_IDLE;
      dst_o  <= '0;
      src1_o <= '0;
      src2_o <= '0;
      q1     <= NONE;
      q2     <= NONE;
      rdy1_o <= 1'b0;
      rdy2_o <= 1'b0;
    end else begin
      case (phase)
        UNIT_IDLE: if (issue_en) begin
          phase  <= UNIT_WAIT;
          dst_o  <= iss_dst;
          src1_o <= iss_src1;
          src2_o <= iss_src2;
          q1     <= iss_q1;
          q2     <= iss_q2;
          rdy1_o <= (iss_q1 == NONE);
          rdy2_o <= (iss_q2 == NONE);
        end
        UNIT_WAIT: begin
          if (rd_go) begin
            phase  <= UNIT_EXEC;
            rdy1_o <= 1'b0;
            rdy2_o <= 1'b0;
          end else begin
            if (wb_valid && q1 == wb_tag) begin
              rdy1_o <= 1'b1;
              q1     <= NONE;
            end
            if (wb_valid && q2 == wb_tag) begin
              rdy2_o <= 1'b1;
              q2     <= NONE;
            end
          end
        end
        UNIT_EXEC: if (wr_go) begin
          phase <= UNIT_IDLE;
          q1    <= NONE;
          q2    <= NONE;
        end
        default: phase <= UNIT_IDLE;
      endcase
    end
  end

  // R2
  unit_free_chk: assert property (@(posedge clk) disable iff (rst)
    issue_en |-> phase == UNIT_IDLE);

  // R5
  read_advance_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> phase == UNIT_EXEC);

  // R8
  wr_exec_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> phase == UNIT_EXEC);
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grant = N'(1) << i;
    end
  end

  // R10
  wb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R10
  wb_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> ((grant & ~req) == '0 && grant != '0));
endmodule

// File: rtl/sb_issue_scoreboard.sv
module sb_issue_scoreboard #(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [$clog2(NUM_FU)-1:0]   in_unit,
  input  logic [$clog2(NUM_REGS)-1:0] in_dst,
  input  logic [$clog2(NUM_REGS)-1:0] in_src1,
  input  logic [$clog2(NUM_REGS)-1:0] in_src2,
  input  logic [NUM_FU-1:0]           done_req,
  output logic                        issue_ok,
  output logic [NUM_FU-1:0]           rd_grant,
  output logic [NUM_FU-1:0]           wr_grant,
  output logic [$clog2(NUM_REGS)-1:0] wr_reg
);
  import sb_pkg::*;

  localparam int UW = $clog2(NUM_FU);
  localparam int RW = $clog2(NUM_REGS);
  localparam int TW = $clog2(NUM_FU + 1);
  localparam logic [TW-1:0] NONE = TW'(NUM_FU);

  unit_phase_e     phase_a [NUM_FU];
  logic [RW-1:0]   dst_a   [NUM_FU];
  logic [RW-1:0]   src1_a  [NUM_FU];
  logic [RW-1:0]   src2_a  [NUM_FU];
  logic [NUM_FU-1:0] rdy1_a, rdy2_a;

  logic [TW-1:0] tag_dst, tag_s1, tag_s2;
  logic [TW-1:0] iss_q1, iss_q2;
  logic [TW-1:0] wb_tag;
  logic          wb_valid;
  logic [NUM_FU-1:0] war_block, wb_req;

  // register result-status table
  sb_reg_tags #(.NUM_REGS(NUM_REGS), .TW(TW), .NONE(NONE)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .set_en   (issue_ok),
    .set_reg  (in_dst),
    .set_tag  (TW'(in_unit)),
    .clr_en   (wb_valid),
    .clr_reg  (wr_reg),
    .look_dst (in_dst),
    .look_s1  (in_src1),
    .look_s2  (in_src2),
    .tag_dst  (tag_dst),
    .tag_s1   (tag_s1),
    .tag_s2   (tag_s2)
  );

  // issue decision: unit free and destination not already pending
  always_comb begin
    issue_ok = in_valid && (phase_a[in_unit] == UNIT_IDLE) && (tag_dst == NONE);
  end

  // a producer writing back this very cycle no longer counts as pending
  assign iss_q1 = (wb_valid && tag_s1 == wb_tag) ? NONE : tag_s1;
  assign iss_q2 = (wb_valid && tag_s2 == wb_tag) ? NONE : tag_s2;

  // per-unit status slots
  for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
    sb_unit_slot #(.RW(RW), .TW(TW), .NONE(NONE)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .issue_en (issue_ok && (in_unit == UW'(u))),
      .iss_dst  (in_dst),
      .iss_src1 (in_src1),
      .iss_src2 (in_src2),
      .iss_q1   (iss_q1),
      .iss_q2   (iss_q2),
      .rd_go    (rd_grant[u]),
      .wr_go    (wr_grant[u]),
      .wb_valid (wb_valid),
      .wb_tag   (wb_tag),
      .phase    (phase_a[u]),
      .dst_o    (dst_a[u]),
      .src1_o   (src1_a[u]),
      .src2_o   (src2_a[u]),
      .rdy1_o   (rdy1_a[u]),
      .rdy2_o   (rdy2_a[u])
    );
    assign rd_grant[u] = (phase_a[u] == UNIT_WAIT) && rdy1_a[u] && rdy2_a[u];
  end

  // write-after-read: hold a writer while an unread ready source names its dst
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      war_block[u] = 1'b0;
      for (int f = 0; f < NUM_FU; f++) begin
        if (phase_a[f] == UNIT_WAIT &&
            ((rdy1_a[f] && src1_a[f] == dst_a[u]) ||
             (rdy2_a[f] && src2_a[f] == dst_a[u])))
          war_block[u] = 1'b1;
      end
      wb_req[u] = done_req[u] && (phase_a[u] == UNIT_EXEC) && !war_block[u];
    end
  end

  sb_wb_arbiter #(.N(NUM_FU)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (wb_req),
    .grant (wr_grant)
  );

  always_comb begin
    wb_valid = |wr_grant;
    wb_tag   = NONE;
    wr_reg   = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (wr_grant[u]) begin
        wb_tag = TW'(u);
        wr_reg = dst_a[u];
      end
    end
  end

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_grant & wr_grant) == '0);

  // R4
  issue_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !issue_ok);
endmodule

// File: tb/test_sb_issue_scoreboard.sv
`timescale 1ns/1ps
module test_sb_issue_scoreboard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_unit = '0;
  logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [3:0] done_req = '0;
  logic       issue_ok;
  logic [3:0] rd_grant, wr_grant;
  logic [2:0] wr_reg;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sb_issue_scoreboard #(.NUM_FU(4), .NUM_REGS(8)) i_sb_issue_scoreboard (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .done_req(done_req), .issue_ok(issue_ok), .rd_grant(rd_grant),
    .wr_grant(wr_grant), .wr_reg(wr_reg)
  );

  // {req, valid, unit, dst, src1, src2, done, exp_issue, exp_rd, exp_wr, exp_wreg}
  localparam int NSTEP = 30;
  localparam logic [31:0] VEC [NSTEP] = '{
    {4'd1, 1'b1,2'd0,3'd1,3'd2,3'd3, 4'b0000, 1'b1,4'b0000,4'b0000,3'd0}, // 0  R1 first issue
    {4'd5, 1'b1,2'd1,3'd4,3'd1,3'd5, 4'b0000, 1'b1,4'b0001,4'b0000,3'd0}, // 1  R5 read after issue
    {4'd3, 1'b1,2'd2,3'd1,3'd6,3'd6, 4'b0000, 1'b0,4'b0000,4'b0000,3'd0}, // 2  R3 dst r1 pending
    {4'd11,1'b1,2'd2,3'd1,3'd6,3'd6, 4'b0001, 1'b0,4'b0000,4'b0001,3'd1}, // 3  R11 write r1
    {4'd6, 1'b1,2'd2,3'd1,3'd6,3'd6, 4'b0000, 1'b1,4'b0010,4'b0000,3'd0}, // 4  R6 consumer reads
    {4'd4, 1'b0,2'd3,3'd7,3'd0,3'd0, 4'b0010, 1'b0,4'b0100,4'b0010,3'd4}, // 5  R4 no valid
    {4'd11,1'b1,2'd0,3'd2,3'd0,3'd0, 4'b0100, 1'b1,4'b0000,4'b0100,3'd1}, // 6  R11
    {4'd5, 1'b1,2'd3,3'd3,3'd0,3'd0, 4'b0000, 1'b1,4'b0001,4'b0000,3'd0}, // 7  R5
    {4'd8, 1'b1,2'd3,3'd7,3'd0,3'd0, 4'b1001, 1'b0,4'b1000,4'b0001,3'd2}, // 8  R8 waiting done ignored
    {4'd11,1'b0,2'd0,3'd0,3'd0,3'd0, 4'b1000, 1'b0,4'b0000,4'b1000,3'd3}, // 9  R11
    {4'd5, 1'b1,2'd2,3'd5,3'd0,3'd0, 4'b0000, 1'b1,4'b0000,4'b0000,3'd0}, // 10 R5
    {4'd5, 1'b1,2'd1,3'd6,3'd0,3'd0, 4'b0000, 1'b1,4'b0100,4'b0000,3'd0}, // 11 R5
    {4'd2, 1'b1,2'd2,3'd7,3'd0,3'd0, 4'b0000, 1'b0,4'b0010,4'b0000,3'd0}, // 12 R2 unit busy
    {4'd10,1'b0,2'd0,3'd0,3'd0,3'd0, 4'b0110, 1'b0,4'b0000,4'b0010,3'd6}, // 13 R10 lowest wins
    {4'd10,1'b0,2'd0,3'd0,3'd0,3'd0, 4'b0100, 1'b0,4'b0000,4'b0100,3'd5}, // 14 R10 loser later
    {4'd5, 1'b1,2'd0,3'd1,3'd0,3'd0, 4'b0000, 1'b1,4'b0000,4'b0000,3'd0}, // 15 R5
    {4'd5, 1'b0,2'd0,3'd0,3'd0,3'd0, 4'b0000, 1'b0,4'b0001,4'b0000,3'd0}, // 16 R5
    {4'd7, 1'b1,2'd3,3'd2,3'd1,3'd1, 4'b0001, 1'b1,4'b0000,4'b0001,3'd1}, // 17 R7 issue during write
    {4'd7, 1'b0,2'd0,3'd0,3'd0,3'd0, 4'b0000, 1'b0,4'b1000,4'b0000,3'd0}, // 18 R7 no extra wait
    {4'd11,1'b0,2'd0,3'd0,3'd0,3'd0, 4'b1000, 1'b0,4'b0000,4'b1000,3'd2}, // 19 R11
    {4'd5, 1'b1,2'd0,3'd3,3'd0,3'd0, 4'b0000, 1'b1,4'b0000,4'b0000,3'd0}, // 20 R5
    {4'd6, 1'b1,2'd1,3'd4,3'd3,3'd5, 4'b0000, 1'b1,4'b0001,4'b0000,3'd0}, // 21 R6 src r3 pending
    {4'd9, 1'b1,2'd2,3'd5,3'd0,3'd0, 4'b0000, 1'b1,4'b0000,4'b0000,3'd0}, // 22 R9 writer of r5
    {4'd5, 1'b0,2'd0,3'd0,3'd0,3'd0, 4'b0000, 1'b0,4'b0100,4'b0000,3'd0}, // 23 R5
    {4'd9, 1'b0,2'd0,3'd0,3'd0,3'd0, 4'b0100, 1'b0,4'b0000,4'b0000,3'd0}, // 24 R9 blocked
    {4'd9, 1'b0,2'd0,3'd0,3'd0,3'd0, 4'b0101, 1'b0,4'b0000,4'b0001,3'd3}, // 25 R9 other unit passes
    {4'd9, 1'b0,2'd0,3'd0,3'd0,3'd0, 4'b0100, 1'b0,4'b0010,4'b0000,3'd0}, // 26 R9 still blocked
    {4'd9, 1'b0,2'd0,3'd0,3'd0,3'd0, 4'b0100, 1'b0,4'b0000,4'b0100,3'd5}, // 27 R9 released
    {4'd11,1'b0,2'd0,3'd0,3'd0,3'd0, 4'b0010, 1'b0,4'b0000,4'b0010,3'd4}, // 28 R11
    {4'd8, 1'b0,2'd0,3'd0,3'd0,3'd0, 4'b1111, 1'b0,4'b0000,4'b0000,3'd0}  // 29 R8 idle done ignored
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] u, input logic [2:0] d,
                       input logic [2:0] s1, input logic [2:0] s2, input logic [3:0] dn);
    in_valid = v; in_unit = u; in_dst = d; in_src1 = s1; in_src2 = s2; done_req = dn;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state: issue possible, no grants despite all done requests
    drive(1'b1, 2'd2, 3'd7, 3'd0, 3'd0, 4'b1111);
    #1;
    check("R1", "issue_ok after reset", int'(issue_ok), 1);
    check("R1", "rd_grant after reset", int'(rd_grant), 0);
    check("R1", "wr_grant after reset", int'(wr_grant), 0);
    drive(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000);

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      drive(VEC[i][27], VEC[i][26:25], VEC[i][24:22], VEC[i][21:19],
            VEC[i][18:16], VEC[i][15:12]);
      #1;
      begin
        string tag;
        tag = $sformatf("R%0d step %0d", VEC[i][31:28], i);
        check(tag, "issue_ok", int'(issue_ok), int'(VEC[i][11]));
        check(tag, "rd_grant", int'(rd_grant), int'(VEC[i][10:7]));
        check(tag, "wr_grant", int'(wr_grant), int'(VEC[i][6:3]));
        if (VEC[i][6:3] != 4'b0000)
          check(tag, "wr_reg", int'(wr_reg), int'(VEC[i][2:0]));
      end
    end

    // R1 reset in mid-flight clears units and tags
    @(negedge clk);
    drive(1'b1, 2'd1, 3'd2, 3'd0, 3'd0, 4'b0000);
    @(negedge clk);
    drive(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 2'd1, 3'd2, 3'd0, 3'd0, 4'b0010);
    #1;
    check("R1", "issue_ok after mid reset", int'(issue_ok), 1);
    check("R1", "rd_grant after mid reset", int'(rd_grant), 0);
    check("R1", "wr_grant after mid reset", int'(wr_grant), 0);
    @(negedge clk);
    drive(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, 4'b0000);
    #1;
    check("R5", "rd_grant after reissue", int'(rd_grant), 4'b0010);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule